// File: doc/BRIEF.md
# Single-Register NAND Flash Bridge

This block lets a processor run a raw 8-bit NAND flash device through a single 32-bit register. Each bus write carries an operation code, a chip-select request and one byte. The bridge turns that write into a command-latch, address-latch or data-write strobe on the flash pins. One operation code arms read mode. After that, every bus read produces one read strobe on the flash and returns the byte it fetched, together with the device busy flag.

A bus access is presented on `bus_valid` with `bus_we` and `bus_wdata` held steady. The bridge holds the access off until the flash strobe sequence is complete. It then raises `bus_done` for exactly one clock, and in that clock `bus_rdata` carries the read result. The flash data bus is split into output, output-enable and input lanes, so the pad ring can build the tristate buffer. Strobe width and the setup and hold intervals are parameters counted in clocks.

Top module: `nfreg_bridge`

## Requirements
- R1: Register bits 30:28 hold the operation code. Code 0 (command), code 1 (address) and code 3 (data write) each cause exactly one low pulse on `nf_we_n` per bus write. Code 2 arms read mode and causes no strobe.
- R2: At the rising edge of `nf_we_n`, a command write shows `nf_cle`=1 and `nf_ale`=0, and an address write shows `nf_ale`=1 and `nf_cle`=0. A data write shows both low. The two latch enables are never high together.
- R3: When bit 31 of the write is 1, `nf_ce_n` is low throughout that access's strobe. When bit 31 is 0, `nf_ce_n` stays high. For reads, the bit 31 value given with the arming write applies. `nf_ce_n` is high whenever no access is in progress.
- R4: Bits 23:16 of a written word appear on `nf_dq_o` with `nf_dq_oe`=1 at the `nf_we_n` rising edge. A data write moves exactly one byte.
- R5: Once read mode is armed, each bus read (with `bus_we`=0) gives exactly one `nf_re_n` pulse. `bus_rdata[23:16]` returns the value that `nf_dq_i` had in the last clock of that pulse. No further write is needed between reads.
- R6: A bus read while read mode is not armed produces no `nf_re_n` pulse and returns the last captured byte. This byte is 0 after reset.
- R7: Writes with codes 4 to 7 cause no strobe and no drive of the data bus, and they leave the armed state unchanged. Writes with codes 0, 1 or 3 disarm read mode.
- R8: `bus_rdata[15]` is 1 when `nf_rb_n` was sampled low through a two-flop synchronizer. All bits of `bus_rdata` other than 23:16 and 15 read 0.
- R9: Each strobe stays low for `PULSE_CLKS` clocks, with at least `SETUP_CLKS` clocks before it and `HOLD_CLKS` clocks after it in which the select, latch enables and data are steady. `bus_done` is high for one clock per access.
- R10: `nf_dq_oe` is 1 only during command, address and data-write accesses, and it is never 1 while `nf_re_n` is low.
- R11: During and straight after reset: `nf_ce_n`, `nf_we_n` and `nf_re_n` are 1; `nf_cle`, `nf_ale`, `nf_dq_oe` and `bus_done` are 0; read mode is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request, held until `bus_done` |
| bus_we | input | 1 | 1 for a register write, 0 for a read |
| bus_wdata | input | 32 | Write word: op code, select, byte |
| bus_rdata | output | 32 | Read word, valid with `bus_done` |
| bus_done | output | 1 | One-clock access completion |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Data bus output lane |
| nf_dq_oe | output | 1 | Data bus output enable |
| nf_dq_i | input | 8 | Data bus input lane |
| nf_rb_n | input | 1 | Ready/busy, low means busy |

## Verification
The assertions assume that the requester holds `bus_valid`, `bus_we` and `bus_wdata` steady until `bus_done` and then drops `bus_valid` for at least one clock. They also assume that `nf_rb_n` changes slowly compared with the two-flop synchronizer. The stimulus issues every access through one task that waits for `bus_done` and then releases the request. It changes `nf_rb_n` only in a directed step that leaves several idle clocks before reading the status. It changes `nf_dq_i` only between accesses, so the byte captured at the end of each read pulse is well defined.

// File: rtl/nfreg_pkg.sv
package nfreg_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned SEL_BIT = 31;
  localparam int unsigned OP_HI   = 30;
  localparam int unsigned OP_LO   = 28;
  localparam int unsigned BYTE_LO = 16;
  localparam int unsigned BUSY_BIT = 15;

  localparam logic [2:0] OP_CMD   = 3'd0;
  localparam logic [2:0] OP_ADDR  = 3'd1;
  localparam logic [2:0] OP_RDARM = 3'd2;
  localparam logic [2:0] OP_WDATA = 3'd3;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_DONE  = 3'd4
  } seq_st_e;

  typedef struct packed {
    logic              latch;
    logic              arm;
    logic              cle;
    logic              ale;
    logic              sel;
    logic [BYTE_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/nfreg_decode.sv
module nfreg_decode
  import nfreg_pkg::*;
(
  input  logic [WORD_W-1:0] wdata,
  output wr_req_t           req
);
  logic [2:0] op_f;

  always_comb begin
    op_f      = wdata[OP_HI:OP_LO];
    req.latch = (op_f == OP_CMD) || (op_f == OP_ADDR) || (op_f == OP_WDATA);
    req.arm   = (op_f == OP_RDARM);
    req.cle   = (op_f == OP_CMD);
    req.ale   = (op_f == OP_ADDR);
    req.sel   = wdata[SEL_BIT];
    req.data  = wdata[BYTE_LO +: BYTE_W];
  end

  always_comb begin
    a_r2_one_latch_enable: assert (!(req.cle && req.ale));
  end
endmodule

// File: rtl/nfreg_rbsync.sv
module nfreg_rbsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_n_async,
  output logic busy
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      logic d_in;
      if (gi == 0) begin : g_first
        assign d_in = rb_n_async;
      end else begin : g_next
        assign d_in = chain_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[gi] <= 1'b1;
        else        chain_q[gi] <= d_in;
      end
    end
  endgenerate

  assign busy = ~chain_q[STAGES-1];

  a_r8_busy_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(rb_n_async, STAGES));
endmodule

// File: rtl/nfreg_seq.sv
module nfreg_seq
  import nfreg_pkg::*;
#(
  parameter int unsigned SETUP_CLKS = 1,
  parameter int unsigned PULSE_CLKS = 3,
  parameter int unsigned HOLD_CLKS  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  wr_req_t           req,
  input  logic [BYTE_W-1:0] dq_i,
  output logic              done,
  output logic [BYTE_W-1:0] last_byte,
  output logic              cle,
  output logic              ale,
  output logic              ce_n,
  output logic              we_n,
  output logic              re_n,
  output logic [BYTE_W-1:0] dq_o,
  output logic              dq_oe
);
  localparam int unsigned MAXC = (SETUP_CLKS > PULSE_CLKS) ?
                                 ((SETUP_CLKS > HOLD_CLKS) ? SETUP_CLKS : HOLD_CLKS) :
                                 ((PULSE_CLKS > HOLD_CLKS) ? PULSE_CLKS : HOLD_CLKS);
  localparam int unsigned CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CLKS - 1);
  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CLKS - 1);
  localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CLKS - 1);

  seq_st_e           st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              armed_q, armed_d;
  logic              rsel_q, rsel_d;
  logic              rdx_q, rdx_d;
  logic [BYTE_W-1:0] last_q, last_d;
  logic              cle_q, cle_d, ale_q, ale_d, ce_n_q, ce_n_d;
  logic              we_n_q, we_n_d, re_n_q, re_n_d, oe_q, oe_d;
  logic [BYTE_W-1:0] dq_q, dq_d;
  logic              cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    armed_d = armed_q;
    rsel_d  = rsel_q;
    rdx_d   = rdx_q;
    last_d  = last_q;
    cle_d   = cle_q;
    ale_d   = ale_q;
    ce_n_d  = ce_n_q;
    we_n_d  = we_n_q;
    re_n_d  = re_n_q;
    oe_d    = oe_q;
    dq_d    = dq_q;
    unique case (st_q)
      ST_IDLE: begin
        if (bus_valid) begin
          if (bus_we) begin
            if (req.latch) begin
              armed_d = 1'b0;
              rdx_d   = 1'b0;
              cle_d   = req.cle;
              ale_d   = req.ale;
              ce_n_d  = ~req.sel;
              dq_d    = req.data;
              oe_d    = 1'b1;
              cnt_d   = SETUP_LD;
              st_d    = ST_SETUP;
            end else begin
              if (req.arm) begin
                armed_d = 1'b1;
                rsel_d  = req.sel;
              end
              st_d = ST_DONE;
            end
          end else if (armed_q) begin
            rdx_d  = 1'b1;
            ce_n_d = ~rsel_q;
            cnt_d  = SETUP_LD;
            st_d   = ST_SETUP;
          end else begin
            st_d = ST_DONE;
          end
        end
      end
      ST_SETUP: begin
        if (cnt_zero) begin
          if (rdx_q) re_n_d = 1'b0;
          else       we_n_d = 1'b0;
          cnt_d = PULSE_LD;
          st_d  = ST_PULSE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_PULSE: begin
        if (cnt_zero) begin
          if (rdx_q) last_d = dq_i;
          we_n_d = 1'b1;
          re_n_d = 1'b1;
          cnt_d  = HOLD_LD;
          st_d   = ST_HOLD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HOLD: begin
        if (cnt_zero) begin
          cle_d  = 1'b0;
          ale_d  = 1'b0;
          ce_n_d = 1'b1;
          oe_d   = 1'b0;
          st_d   = ST_DONE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      rsel_q  <= 1'b0;
      rdx_q   <= 1'b0;
      last_q  <= '0;
      cle_q   <= 1'b0;
      ale_q   <= 1'b0;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      re_n_q  <= 1'b1;
      oe_q    <= 1'b0;
      dq_q    <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      rsel_q  <= rsel_d;
      rdx_q   <= rdx_d;
      last_q  <= last_d;
      cle_q   <= cle_d;
      ale_q   <= ale_d;
      ce_n_q  <= ce_n_d;
      we_n_q  <= we_n_d;
      re_n_q  <= re_n_d;
      oe_q    <= oe_d;
      dq_q    <= dq_d;
    end
  end

  assign done      = (st_q == ST_DONE);
  assign last_byte = last_q;
  assign cle       = cle_q;
  assign ale       = ale_q;
  assign ce_n      = ce_n_q;
  assign we_n      = we_n_q;
  assign re_n      = re_n_q;
  assign dq_o      = dq_q;
  assign dq_oe     = oe_q;

  // Strobe width checker: counts low clocks independently of the FSM counter.
  logic [CW:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 low_run_q <= '0;
    else if (!we_n_q || !re_n_q) low_run_q <= low_run_q + 1'b1;
    else                        low_run_q <= '0;
  end

  a_r9_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(we_n_q) || $rose(re_n_q)) |-> ($past(low_run_q) == (CW+1)'(PULSE_CLKS - 1)));
  a_r9_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_data_held_at_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_q) |-> (oe_q && $stable(dq_q)));
  a_r10_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n_q |-> !oe_q);
  a_r2_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle_q && ale_q));
  a_r3_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (ce_n_q && we_n_q && re_n_q && !oe_q));
  a_r1_one_strobe_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_q && !re_n_q));
endmodule

// File: rtl/nfreg_bridge.sv
module nfreg_bridge
  import nfreg_pkg::*;
#(
  parameter int unsigned SETUP_CLKS  = 1,
  parameter int unsigned PULSE_CLKS  = 3,
  parameter int unsigned HOLD_CLKS   = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_done,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_ce_n,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic [7:0]  nf_dq_o,
  output logic        nf_dq_oe,
  input  logic [7:0]  nf_dq_i,
  input  logic        nf_rb_n
);
  wr_req_t           req;
  logic              busy;
  logic [BYTE_W-1:0] last_byte;

  nfreg_decode u_decode (
    .wdata (bus_wdata),
    .req   (req)
  );

  nfreg_rbsync #(.STAGES(SYNC_STAGES)) u_rbsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rb_n_async (nf_rb_n),
    .busy       (busy)
  );

  nfreg_seq #(
    .SETUP_CLKS (SETUP_CLKS),
    .PULSE_CLKS (PULSE_CLKS),
    .HOLD_CLKS  (HOLD_CLKS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .req       (req),
    .dq_i      (nf_dq_i),
    .done      (bus_done),
    .last_byte (last_byte),
    .cle       (nf_cle),
    .ale       (nf_ale),
    .ce_n      (nf_ce_n),
    .we_n      (nf_we_n),
    .re_n      (nf_re_n),
    .dq_o      (nf_dq_o),
    .dq_oe     (nf_dq_oe)
  );

  always_comb begin
    bus_rdata                       = '0;
    bus_rdata[BYTE_LO +: BYTE_W]    = last_byte;
    bus_rdata[BUSY_BIT]             = busy;
  end

  a_r6_quiet_when_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done && !bus_we) |-> nf_re_n);
endmodule

// File: tb/nfreg_bridge_tb.sv
module nfreg_bridge_tb;
  localparam int PULSE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_done;
  logic        nf_cle, nf_ale, nf_ce_n, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0]  nf_dq_o;
  logic [7:0]  nf_dq_i = 8'h00;
  logic        nf_rb_n = 1'b1;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  nfreg_bridge u_dut (.*);

  // pin monitor, sampled away from the active edge
  int we_rises = 0, re_rises = 0, we_low = 0, re_low = 0, oe_seen = 0, oe_on_read = 0;
  int lat_width, rd_width;
  logic lat_cle, lat_ale, lat_ce_n, lat_oe, rd_ce_n;
  logic [7:0] lat_dq;
  logic prev_we = 1'b1, prev_re = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!nf_we_n) we_low++;
      if (!nf_re_n) begin re_low++; rd_ce_n = nf_ce_n; end
      if (nf_dq_oe) oe_seen++;
      if (nf_dq_oe && !nf_re_n) oe_on_read++;
      if (!prev_we && nf_we_n) begin
        we_rises++; lat_cle = nf_cle; lat_ale = nf_ale; lat_dq = nf_dq_o;
        lat_oe = nf_dq_oe; lat_ce_n = nf_ce_n; lat_width = we_low; we_low = 0;
      end
      if (!prev_re && nf_re_n) begin re_rises++; rd_width = re_low; re_low = 0; end
      prev_we = nf_we_n; prev_re = nf_re_n;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input logic sel, input logic [2:0] op, input logic [7:0] b);
    return {sel, op, 4'h0, b, 16'h0};
  endfunction

  function automatic int exp_we_pulses(input logic we, input logic [2:0] op);
    return (we && (op == 3'd0 || op == 3'd1 || op == 3'd3)) ? 1 : 0;
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [7:0] b, input logic busy);
    return {8'h00, b, busy, 15'h0};
  endfunction

  logic [31:0] rd;
  task automatic access(input logic we, input logic [31:0] w);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_wdata = w;
    do @(negedge clk); while (!bus_done);
    rd = bus_rdata;
    bus_valid = 1'b0;
    @(negedge clk);
    chk("R9 done one clock", {31'b0, bus_done}, 32'd0);
  endtask

  // bench model state
  logic       m_armed = 1'b0, m_sel = 1'b0;
  logic [7:0] m_last = 8'h00;

  task automatic run_op(input logic we, input logic [2:0] op, input logic sel, input logic [7:0] b);
    int w0, r0, o0;
    w0 = we_rises; r0 = re_rises; o0 = oe_seen;
    if (!we) nf_dq_i = b;
    access(we, mk_word(sel, op, b));
    chk("R1 write strobe count", 32'(we_rises - w0), 32'(exp_we_pulses(we, op)));
    chk("R5/R6 read strobe count", 32'(re_rises - r0), (!we && m_armed) ? 32'd1 : 32'd0);
    if (exp_we_pulses(we, op) == 1) begin
      chk("R2 cle at latch", {31'b0, lat_cle}, {31'b0, op == 3'd0});
      chk("R2 ale at latch", {31'b0, lat_ale}, {31'b0, op == 3'd1});
      chk("R4 byte at latch", {24'b0, lat_dq}, {24'b0, b});
      chk("R4 oe at latch", {31'b0, lat_oe}, 32'd1);
      chk("R3 ce at latch", {31'b0, lat_ce_n}, {31'b0, ~sel});
      chk("R9 we width", 32'(lat_width), 32'(PULSE));
      m_armed = 1'b0;
    end else if (we) begin
      chk("R7 no drive on ignored or arm", 32'(oe_seen - o0), 32'd0);
      if (op == 3'd2) begin m_armed = 1'b1; m_sel = sel; end
    end else begin
      chk("R7/R10 no drive on read", 32'(oe_seen - o0), 32'd0);
      if (m_armed) begin
        m_last = b;
        chk("R9 re width", 32'(rd_width), 32'(PULSE));
        chk("R3 ce during read", {31'b0, rd_ce_n}, {31'b0, ~m_sel});
      end
      chk("R5/R6/R8 read word", rd, exp_rdata(m_last, 1'b0));
    end
    chk("R3 idle deselect", {31'b0, nf_ce_n}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset pins", {26'b0, nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe},
        {26'b0, 6'b111000});
    chk("R11 reset done", {31'b0, bus_done}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R6 unarmed read after reset returns zero
    run_op(1'b0, 3'd0, 1'b0, 8'h5a);
    // R2 command and address
    run_op(1'b1, 3'd0, 1'b1, 8'h70);
    run_op(1'b1, 3'd1, 1'b1, 8'h12);
    // R3 deselected data write
    run_op(1'b1, 3'd3, 1'b0, 8'hc3);
    // R5 arm then three reads with no write between
    run_op(1'b1, 3'd2, 1'b1, 8'h00);
    run_op(1'b0, 3'd0, 1'b0, 8'ha1);
    run_op(1'b0, 3'd0, 1'b0, 8'h3c);
    run_op(1'b0, 3'd0, 1'b0, 8'hff);
    // R7 ignored codes keep read mode armed
    for (int k = 4; k < 8; k++) run_op(1'b1, 3'(k), 1'b1, 8'h99);
    run_op(1'b0, 3'd0, 1'b0, 8'h42);
    // R7 data write disarms; R6 next read returns last byte
    run_op(1'b1, 3'd3, 1'b1, 8'h01);
    run_op(1'b0, 3'd0, 1'b0, 8'h77);
    // R8 busy flag through synchronizer
    nf_rb_n = 1'b0;
    repeat (4) @(negedge clk);
    access(1'b0, 32'h0);
    chk("R8 busy set", rd, exp_rdata(m_last, 1'b1));
    nf_rb_n = 1'b1;
    repeat (4) @(negedge clk);
    access(1'b0, 32'h0);
    chk("R8 busy clear", rd, exp_rdata(m_last, 1'b0));
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic we_r;
      we_r = ($urandom % 3) != 0;
      run_op(we_r, 3'($urandom % 8), 1'($urandom), 8'($urandom));
    end
    chk("R10 never drove while reading", 32'(oe_on_read), 32'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule